// File: doc/BRIEF.md
# Serial Channel Shift-and-Latch Controller

This block is the digital front end of a multi-channel LED sink driver. A serial clock, a data line, a latch strobe and a dual-role blank pin feed a common shift register and an on/off latch that holds one enable bit per channel. All pins are sampled in the `clk` domain. Their rising edges are found by comparing each pin with its value on the previous `clk` edge. Any synchronizers sit outside this block.

A rising edge on the serial clock shifts one data bit into the register. A rising edge on the latch strobe copies the register into the channel latch. At that same edge the register can optionally be reloaded with a status word taken from an input port, so that the status can be shifted out afterwards. A mode bit gives the blank pin one of two roles. In one role it masks every channel enable. In the other it selects whether the serial output is taken from the mid-point tap or from the last bit of the register, which lets half-length or full-length daisy chains be built.

Top module: `slsl_iface`

## Requirements
- R1: Each low-to-high transition of `ser_clk`, seen at a `clk` edge, shifts the register by one place toward bit 15 and loads `ser_din` into bit 0. Holding `ser_clk` high for several cycles shifts only once.
- R2: Each low-to-high transition of `lat_in` copies the register into the channel latch. `chan_en[i]` is 1 (channel on) when latch bit i is 1 and the outputs are not blanked.
- R3: When `stat_load` is 1 at a latch transition, the register is replaced by `stat_word`. When `stat_load` is 0, the latch transition leaves the register unchanged.
- R4: When a shift transition and a latch transition fall in the same `clk` cycle, the latch receives the register contents from before the shift. The register then takes `stat_word` if `stat_load` is 1, and otherwise takes the shifted value.
- R5: `ser_dout` equals register bit 7 when `blank_mode` is 0 and `blank_in` is 0. In every other combination it equals register bit 15.
- R6: When `blank_mode` is 1 and `blank_in` is 1, all of `chan_en` is 0. The latch keeps its contents, and they reappear when `blank_in` returns to 0.
- R7: When `blank_mode` is 0, `blank_in` has no effect on `chan_en`.
- R8: While `rst_n` is 0, the register and the latch clear to zero, so `chan_en` is 0 and `ser_dout` is 0.
- R9: `ser_dout` shows the register as it stands after the most recent shift, in the same cycle that the shift completes, so that chained devices can share one serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock pin (level, edge-detected) |
| ser_din | input | 1 | Serial data input |
| lat_in | input | 1 | Latch strobe pin (level, edge-detected) |
| blank_in | input | 1 | Blank pin: output mask or serial-out tap select |
| blank_mode | input | 1 | 1: blank pin masks outputs; 0: blank pin selects the tap |
| stat_load | input | 1 | Reload the register with the status word at a latch edge |
| stat_word | input | 16 | Status word loaded into the register |
| ser_dout | output | 1 | Serial data output |
| chan_en | output | 16 | Per-channel on/off enables |

## Verification
A shift edge and a latch edge can arrive in the same `clk` cycle. The latch must then capture the register as it stood before the shift, while the register either shifts or takes the status word. The bench raises `ser_clk` and `lat_in` on the same falling edge of `clk`, once with `stat_load` low and once with it high. It judges the result from `chan_en` straight away, and then again after a second, plain latch edge that exposes what the register now holds.

// File: rtl/slsl_pkg.sv
package slsl_pkg;
   // Which register bit drives the serial output
   typedef enum logic {
      TAP_FULL = 1'b0,
      TAP_HALF = 1'b1
   } tap_e;
endpackage

// File: rtl/slsl_rise_det.sv
module slsl_rise_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign rise[i] = pin[i] & ~prev_q[i];
   end

   AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      rise[0] |=> !rise[0]) else $error("double rise"); // R1
endmodule

// File: rtl/slsl_shift_reg.sv
module slsl_shift_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("slsl_shift_reg: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load_en)  q <= load_val;
      else if (shift_en) q <= {q[W-2:0], din};
   end

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])))
      else $error("shift mismatch"); // R1
   AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> q == $past(load_val)) else $error("status load"); // R3
   AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !shift_en) |=> $stable(q)) else $error("reg moved"); // R3
endmodule

// File: rtl/slsl_out_latch.sv
module slsl_out_latch #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (capture) q <= d;
   end

   AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> q == $past(d)) else $error("latch copy"); // R2
   AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(q)) else $error("latch drift"); // R6
endmodule

// File: rtl/slsl_iface.sv
module slsl_iface
   import slsl_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int TAP_HALF_BIT = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_din,
   input  logic           lat_in,
   input  logic           blank_in,
   input  logic           blank_mode,
   input  logic           stat_load,
   input  logic [NCH-1:0] stat_word,
   output logic           ser_dout,
   output logic [NCH-1:0] chan_en
);
   localparam int TAP_FULL_BIT = NCH - 1;

   if (NCH < 2 || TAP_HALF_BIT >= NCH || TAP_HALF_BIT < 0) begin : g_bad_cfg
      $error("slsl_iface: NCH >= 2 and TAP_HALF_BIT < NCH required");
   end

   logic [1:0]     rise;
   logic           sclk_rise, lat_rise;
   logic [NCH-1:0] sr_q, latch_q;
   logic           blanked;
   tap_e           tap_sel;

   slsl_rise_det #(.N(2)) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  ({lat_in, ser_clk}),
      .rise (rise)
   );
   assign sclk_rise = rise[0];
   assign lat_rise  = rise[1];

   slsl_shift_reg #(.W(NCH)) u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(sclk_rise),
      .din     (ser_din),
      .load_en (lat_rise & stat_load),
      .load_val(stat_word),
      .q       (sr_q)
   );

   slsl_out_latch #(.W(NCH)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(lat_rise),
      .d      (sr_q),
      .q      (latch_q)
   );

   // Blank pin role chosen by the mode bit
   assign blanked = blank_mode & blank_in;
   assign tap_sel = (!blank_mode && !blank_in) ? TAP_HALF : TAP_FULL;
   assign ser_dout = (tap_sel == TAP_HALF) ? sr_q[TAP_HALF_BIT] : sr_q[TAP_FULL_BIT];

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign chan_en[c] = latch_q[c] & ~blanked;
   end

   AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_mode && blank_in) |-> chan_en == '0) else $error("blank leak"); // R6
   AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && lat_rise) |=> latch_q == $past(sr_q)) else $error("collision"); // R4
   AST_NO_BLANK_M0: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_mode |-> chan_en == latch_q) else $error("mode0 mask"); // R7
endmodule

// File: tb/tb_slsl_iface.sv
module tb_slsl_iface;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_din = 1'b0, lat_in = 1'b0;
   logic        blank_in = 1'b0, blank_mode = 1'b0, stat_load = 1'b0;
   logic [15:0] stat_word = '0;
   logic        ser_dout;
   logic [15:0] chan_en;
   int n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   slsl_iface dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .lat_in(lat_in), .blank_in(blank_in), .blank_mode(blank_mode),
      .stat_load(stat_load), .stat_word(stat_word),
      .ser_dout(ser_dout), .chan_en(chan_en)
   );

   localparam logic [15:0] PATS [6] = '{16'hA5C3, 16'h0001, 16'h8000,
                                        16'hFFFF, 16'h0080, 16'h1234};

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Each task starts and ends at a falling edge of clk
   task automatic shift_bit(input logic b);
      ser_din = b; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
      @(negedge clk);
   endtask

   task automatic latch(input logic ld);
      stat_load = ld; lat_in = 1'b1;
      @(negedge clk); lat_in = 1'b0; stat_load = 1'b0;
      @(negedge clk);
   endtask

   task automatic shift_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) shift_bit(w[i]);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R8 reset chan_en", chan_en, 16'h0);
      chk("R8 reset dout", {15'b0, ser_dout}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table-driven patterns
      for (int p = 0; p < 6; p++) begin
         shift_word(PATS[p]);
         latch(1'b0);
         chk("R2 latch copy", chan_en, PATS[p]);
         blank_mode = 1'b0; blank_in = 1'b0; #1;
         chk("R5 tap bit7", {15'b0, ser_dout}, {15'b0, PATS[p][7]});
         blank_in = 1'b1; #1;
         chk("R5 tap bit15", {15'b0, ser_dout}, {15'b0, PATS[p][15]});
         chk("R7 blank ignored in mode0", chan_en, PATS[p]);
         blank_in = 1'b0;
         @(negedge clk);
      end

      // R3: latch without load keeps register; bit15 tap after one more shift = old bit14 (R9)
      blank_in = 1'b1;
      shift_bit(1'b0);
      chk("R9 daisy dout", {15'b0, ser_dout}, {15'b0, PATS[5][14]});
      blank_in = 1'b0;
      latch(1'b0);
      chk("R3 reg kept over latch", chan_en, {PATS[5][14:0], 1'b0});
      latch(1'b0);
      chk("R3 no-load latch unchanged reg", chan_en, {PATS[5][14:0], 1'b0});

      // R3: status load
      stat_word = 16'h5A3C;
      latch(1'b1);
      chk("R3 latch got pre-load reg", chan_en, {PATS[5][14:0], 1'b0});
      chk("R3 status tap7", {15'b0, ser_dout}, 16'h0);
      latch(1'b0);
      chk("R3 status in reg", chan_en, 16'h5A3C);

      // R4: collision without load
      ser_din = 1'b1; ser_clk = 1'b1; lat_in = 1'b1; stat_load = 1'b0;
      @(negedge clk); ser_clk = 1'b0; lat_in = 1'b0; @(negedge clk);
      chk("R4 collide latch pre-shift", chan_en, 16'h5A3C);
      latch(1'b0);
      chk("R4 collide reg shifted", chan_en, 16'hB479);

      // R4: collision with load
      stat_word = 16'hC001;
      ser_din = 1'b0; ser_clk = 1'b1; lat_in = 1'b1; stat_load = 1'b1;
      @(negedge clk); ser_clk = 1'b0; lat_in = 1'b0; stat_load = 1'b0; @(negedge clk);
      chk("R4 collide+load latch", chan_en, 16'hB479);
      latch(1'b0);
      chk("R4 collide+load reg", chan_en, 16'hC001);

      // R6 / R5 in mode 1
      blank_mode = 1'b1; blank_in = 1'b1; #1;
      chk("R6 blanked", chan_en, 16'h0);
      chk("R5 mode1 blank high tap15", {15'b0, ser_dout}, 16'h1);
      @(negedge clk); @(negedge clk);
      blank_in = 1'b0; #1;
      chk("R6 latch kept", chan_en, 16'hC001);
      chk("R5 mode1 blank low tap15", {15'b0, ser_dout}, 16'h1);
      blank_mode = 1'b0;
      @(negedge clk);

      // R1: held-high serial clock shifts only once
      ser_din = 1'b1; ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0; @(negedge clk);
      latch(1'b0);
      chk("R1 single shift per rise", chan_en, 16'h8003);

      // R8: reset mid-run
      rst_n = 1'b0; #1;
      chk("R8 reset clears latch", chan_en, 16'h0);
      chk("R8 reset clears reg", {15'b0, ser_dout}, 16'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule